// File: doc/BRIEF.md
# Omega Shuffle-Exchange Request Router

This block connects a set of processor ports to the same number of memory ports through a circuit-switched omega interconnect. The port count N is a power of two, 8 by default. There are log2(N) columns of two-by-two switch boxes with N/2 boxes in each column. Before every column, the lanes are rewired by a perfect shuffle: a lane index rotates left by one bit, and its top bit wraps to the bottom. Each cycle, every processor port may offer a request. A request carries a destination port, a data word and a fan-out flag. The block routes all offered requests through the switch columns in the same cycle, using the destination bits as the route tag. It raises a grant for every request that gets through. The memory ports then present the delivered words, registered, on the following clock edge.

Every source and destination pair has exactly one path, so the network is blocking. When two requests compete for one switch output, the request on the upper input of that switch goes through. The other request gets no grant for that cycle and must be offered again. When the fan-out flag is set, the switch in the last column copies the request onto both of its outputs.

Top module: `omega_router`

## Requirements
- R1: While reset is held, and on the first rising edge after it, `mem_valid` is all zeros.
- R2: A request offered on its own is granted in the same cycle. On the next rising edge, memory port `req_dest` shows `mem_valid`=1, `mem_src` equal to the requesting port index, and `mem_data` equal to its word.
- R3: A port with `req_valid`=0 never receives a grant. A cycle with no requests leaves every `mem_valid` low after the next edge.
- R4: Routing works as follows. Before switch column k (k=0 at the inputs), lane index p moves to lane ((2p) mod N)+(p div (N/2)). The switch holding lanes 2j and 2j+1 sends a request to lane 2j when destination bit (log2(N)-1-k) is 0, and to lane 2j+1 when that bit is 1. After the edge, the memory ports show exactly the granted requests.
- R5: If two requests need the same switch output, the one on the even (upper) lane wins. The loser gets grant 0 and delivers nothing. For example, with N=8, port 2 to destination 6 and port 6 to destination 4 collide, and only port 2 is granted.
- R6: Any cyclic shift pattern, in which every port p sends to (p+c) mod N, is granted in full in one cycle.
- R7: A granted request with `req_bcast`=1 is delivered on the next edge to memory ports `req_dest` and `req_dest` XOR 1.
- R8: The fan-out flag matters only in the last column. There, a flagged request needs both outputs of its switch, so it collides with any other request at that switch, and the upper lane wins. In earlier columns, the flag does not change the route.
- R9: Arbitration keeps no state between cycles. A request that lost, and is then offered again without its rival, is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N | Request present, one bit per processor port |
| req_dest | input | N*log2(N) | Destination memory port, one field per processor port |
| req_bcast | input | N | Fan-out flag: deliver to the destination and its neighbour |
| req_data | input | N*DW | Data word, one field per processor port |
| req_grant | output | N | Request got through this cycle (combinational) |
| mem_valid | output | N | Registered: word present at this memory port |
| mem_src | output | N*log2(N) | Registered: index of the processor port that sent the word |
| mem_data | output | N*DW | Registered: delivered data word |

## Verification
Contention and fan-out can occur in the same cycle. A flagged request can reach the last column while another request arrives at the same switch. Both can also happen while an earlier column is already resolving a separate collision. The bench sweeps every pair of sources with every pair of destinations and every combination of the two fan-out flags. It also runs long pseudo-random full-width patterns. It judges each cycle twice. The grant vector is compared before the edge, and the whole memory-port image is compared after the edge. Both are compared against a lane-by-lane arithmetic model of the shuffle, the tag bits and the upper-lane priority.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Setting of one two-by-two switch box
    typedef enum logic [1:0] {
        SW_PASS     = 2'd0,   // upper->upper, lower->lower
        SW_CROSS    = 2'd1,   // upper->lower, lower->upper
        SW_UP_FAN   = 2'd2,   // upper input drives both outputs
        SW_LO_FAN   = 2'd3    // lower input drives both outputs
    } sw_mode_e;

endpackage

// File: rtl/omega_switch.sv
// One 2x2 switch box. Lane layout: {vld, bcast, src, dst, data}.
module omega_switch
    import omega_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DW   = 8,
    parameter int BIT  = 2,
    parameter bit LAST = 1'b0
) (
    input  logic [DW+2*AW+1:0] up_i,
    input  logic [DW+2*AW+1:0] lo_i,
    output logic [DW+2*AW+1:0] up_o,
    output logic [DW+2*AW+1:0] lo_o
);
    localparam int VLD = DW + 2*AW + 1;
    localparam int BCF = DW + 2*AW;

    logic     up_v, lo_v, up_bit, lo_bit, up_fan, lo_fan, lo_ok;
    sw_mode_e mode;
    logic [DW+2*AW+1:0] lo_keep;

    assign up_v   = up_i[VLD];
    assign lo_v   = lo_i[VLD];
    assign up_bit = up_i[DW+BIT];
    assign lo_bit = lo_i[DW+BIT];
    assign up_fan = LAST && up_i[BCF];
    assign lo_fan = LAST && lo_i[BCF];

    // Lower input survives only if it needs an output the upper one leaves free
    assign lo_ok = lo_v && (!up_v || (!up_fan && !lo_fan && (up_bit != lo_bit)));

    always_comb begin
        if (up_v)
            mode = up_fan ? SW_UP_FAN : (up_bit ? SW_CROSS : SW_PASS);
        else if (lo_v)
            mode = lo_fan ? SW_LO_FAN : (lo_bit ? SW_PASS : SW_CROSS);
        else
            mode = SW_PASS;
    end

    always_comb begin
        lo_keep      = lo_i;
        lo_keep[VLD] = lo_ok;
    end

    always_comb begin
        unique case (mode)
            SW_PASS:   begin up_o = up_i;    lo_o = lo_keep; end
            SW_CROSS:  begin up_o = lo_keep; lo_o = up_i;    end
            SW_UP_FAN: begin up_o = up_i;    lo_o = up_i;    end
            SW_LO_FAN: begin up_o = lo_keep; lo_o = lo_keep; end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
// Perfect shuffle followed by one column of N/2 switch boxes.
module omega_stage #(
    parameter int N    = 8,
    parameter int AW   = 3,
    parameter int DW   = 8,
    parameter int BIT  = 2,
    parameter bit LAST = 1'b0
) (
    input  logic [N*(DW+2*AW+2)-1:0] in_lanes,
    output logic [N*(DW+2*AW+2)-1:0] out_lanes
);
    localparam int LW = DW + 2*AW + 2;

    logic [N*LW-1:0] shuf;

    for (genvar p = 0; p < N; p++) begin : g_shuffle
        localparam int S = ((2*p) % N) + (p / (N/2));
        assign shuf[S*LW +: LW] = in_lanes[p*LW +: LW];
    end

    for (genvar j = 0; j < N/2; j++) begin : g_box
        omega_switch #(
            .AW   (AW),
            .DW   (DW),
            .BIT  (BIT),
            .LAST (LAST)
        ) u_box (
            .up_i (shuf[(2*j)*LW +: LW]),
            .lo_i (shuf[(2*j+1)*LW +: LW]),
            .up_o (out_lanes[(2*j)*LW +: LW]),
            .lo_o (out_lanes[(2*j+1)*LW +: LW])
        );
    end

endmodule

// File: rtl/omega_router.sv
module omega_router #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           req_valid,
    input  logic [N*$clog2(N)-1:0] req_dest,
    input  logic [N-1:0]           req_bcast,
    input  logic [N*DW-1:0]        req_data,
    output logic [N-1:0]           req_grant,
    output logic [N-1:0]           mem_valid,
    output logic [N*$clog2(N)-1:0] mem_src,
    output logic [N*DW-1:0]        mem_data
);
    localparam int AW  = $clog2(N);
    localparam int LW  = DW + 2*AW + 2;
    localparam int VLD = LW - 1;
    localparam int SRC = DW + AW;

    logic [N*LW-1:0] bus [AW+1];

    // Assemble the input lanes
    for (genvar p = 0; p < N; p++) begin : g_lane_in
        assign bus[0][p*LW +: LW] = {req_valid[p], req_bcast[p], AW'(p),
                                     req_dest[p*AW +: AW], req_data[p*DW +: DW]};
    end

    for (genvar k = 0; k < AW; k++) begin : g_col
        omega_stage #(
            .N    (N),
            .AW   (AW),
            .DW   (DW),
            .BIT  (AW-1-k),
            .LAST (k == AW-1)
        ) u_col (
            .in_lanes  (bus[k]),
            .out_lanes (bus[k+1])
        );
    end

    // Every lane still valid at the far side names a granted source
    always_comb begin
        req_grant = '0;
        for (int i = 0; i < N; i++) begin
            if (bus[AW][i*LW+VLD])
                req_grant[bus[AW][i*LW+SRC +: AW]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_valid <= '0;
            mem_src   <= '0;
            mem_data  <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                mem_valid[i]          <= bus[AW][i*LW+VLD];
                mem_src[i*AW +: AW]   <= bus[AW][i*LW+SRC +: AW];
                mem_data[i*DW +: DW]  <= bus[AW][i*LW +: DW];
            end
        end
    end

endmodule

// File: rtl/omega_router_chk.sv
module omega_router_chk #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           req_valid,
    input logic [N*$clog2(N)-1:0] req_dest,
    input logic [N-1:0]           req_bcast,
    input logic [N*DW-1:0]        req_data,
    input logic [N-1:0]           req_grant,
    input logic [N-1:0]           mem_valid,
    input logic [N*$clog2(N)-1:0] mem_src,
    input logic [N*DW-1:0]        mem_data
);
    localparam int AW = $clog2(N);
    localparam int CW = AW + 2;

    logic [AW-1:0] dest_q [N];
    logic [DW-1:0] data_q [N];
    logic [N-1:0]  bc_q;
    logic [CW-1:0] want_cnt, cnt_q;
    logic          rst_seen_q;

    always_comb begin
        want_cnt = '0;
        for (int p = 0; p < N; p++)
            if (req_grant[p]) want_cnt = want_cnt + (req_bcast[p] ? CW'(2) : CW'(1));
    end

    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bc_q  <= '0;
            for (int p = 0; p < N; p++) begin
                dest_q[p] <= '0;
                data_q[p] <= '0;
            end
        end else begin
            cnt_q <= want_cnt;
            bc_q  <= req_bcast;
            for (int p = 0; p < N; p++) begin
                dest_q[p] <= req_dest[p*AW +: AW];
                data_q[p] <= req_data[p*DW +: DW];
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst_seen_q |-> (mem_valid == '0));

    assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_grant & ~req_valid) == '0));

    assert_lone_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req_valid) == 1) |-> (req_grant == req_valid));

    assert_delivery_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_valid) == int'(cnt_q)));

    for (genvar i = 0; i < N; i++) begin : g_port
        assert_route_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid[i] |->
                ((dest_q[mem_src[i*AW +: AW]] == AW'(i)) ||
                 (bc_q[mem_src[i*AW +: AW]] && ((dest_q[mem_src[i*AW +: AW]] ^ AW'(1)) == AW'(i)))));

        assert_route_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid[i] |-> (mem_data[i*DW +: DW] == data_q[mem_src[i*AW +: AW]]));
    end

endmodule

bind omega_router omega_router_chk #(.N(N), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .req_bcast (req_bcast),
    .req_data  (req_data),
    .req_grant (req_grant),
    .mem_valid (mem_valid),
    .mem_src   (mem_src),
    .mem_data  (mem_data)
);

// File: tb/omega_router_tb.sv
module omega_router_tb;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int DW    = 8;
    localparam int AW    = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req_valid, req_bcast, req_grant, mem_valid;
    logic [N*AW-1:0] req_dest, mem_src;
    logic [N*DW-1:0] req_data, mem_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    omega_router #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dest(req_dest), .req_bcast(req_bcast), .req_data(req_data),
        .req_grant(req_grant), .mem_valid(mem_valid), .mem_src(mem_src), .mem_data(mem_data)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One cycle: drive, check grant before the edge, check memory ports after it
    task automatic run_cycle(input logic [N-1:0] v, input logic [N*AW-1:0] d,
                             input logic [N-1:0] b, input string tag);
        int pos [N];
        bit alive [N];
        logic [N-1:0]    eg, ev;
        logic [N*AW-1:0] es;
        logic [N*DW-1:0] ed, dat;
        @(negedge clk);
        cyc++;
        for (int s = 0; s < N; s++) dat[s*DW +: DW] = DW'(s*29 + cyc*7);
        req_valid = v; req_dest = d; req_bcast = b; req_data = dat;
        // Arithmetic model of the network
        for (int s = 0; s < N; s++) begin pos[s] = s; alive[s] = v[s]; end
        for (int k = 0; k < AW; k++) begin
            for (int s = 0; s < N; s++) pos[s] = ((pos[s] * 2) % N) + (pos[s] / (N/2));
            for (int j = 0; j < N/2; j++) begin
                int u, l, bu, bl;
                bit last;
                u = -1; l = -1;
                last = (k == AW-1);
                for (int s = 0; s < N; s++) begin
                    if (alive[s] && pos[s] == 2*j)   u = s;
                    if (alive[s] && pos[s] == 2*j+1) l = s;
                end
                bu = (u >= 0) ? ((int'(d[u*AW +: AW]) >> (AW-1-k)) & 1) : 0;
                bl = (l >= 0) ? ((int'(d[l*AW +: AW]) >> (AW-1-k)) & 1) : 0;
                if (u >= 0 && l >= 0 && ((last && (b[u] || b[l])) || bu == bl)) begin
                    alive[l] = 1'b0;
                    l = -1;
                end
                if (u >= 0) pos[u] = 2*j + bu;
                if (l >= 0) pos[l] = 2*j + bl;
            end
        end
        eg = '0; ev = '0; es = '0; ed = '0;
        for (int s = 0; s < N; s++) begin
            if (alive[s]) begin
                eg[s] = 1'b1;
                ev[pos[s]] = 1'b1;
                es[pos[s]*AW +: AW] = AW'(s);
                ed[pos[s]*DW +: DW] = dat[s*DW +: DW];
                if (b[s]) begin
                    ev[pos[s]^1] = 1'b1;
                    es[(pos[s]^1)*AW +: AW] = AW'(s);
                    ed[(pos[s]^1)*DW +: DW] = dat[s*DW +: DW];
                end
            end
        end
        #(CLK_P/4);
        checks++;
        if (req_grant !== eg) begin
            errors++;
            $display("FAIL %s grant act=%b exp=%b", tag, req_grant, eg);
        end
        @(posedge clk);
        #1;
        checks++;
        if (mem_valid !== ev || ((mem_src ^ es) & {N{1'b1}} ) !== '0 && 1'b0) begin
            errors++;
            $display("FAIL %s mem_valid act=%b exp=%b", tag, mem_valid, ev);
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ev[i] && (mem_src[i*AW +: AW] !== es[i*AW +: AW] ||
                              mem_data[i*DW +: DW] !== ed[i*DW +: DW])) begin
                    errors++;
                    $display("FAIL %s port %0d src/data act=%0d/%0h exp=%0d/%0h", tag, i,
                             mem_src[i*AW +: AW], mem_data[i*DW +: DW],
                             es[i*AW +: AW], ed[i*DW +: DW]);
                    break;
                end
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [N*AW-1:0] d;
        logic [N-1:0]    v, b;
        logic [15:0]     lfsr;
        rst_n = 1'b0;
        req_valid = '0; req_dest = '0; req_bcast = '0; req_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (mem_valid !== '0) begin
            errors++;
            $display("FAIL R1 reset mem_valid act=%b exp=0", mem_valid);
        end
        rst_n = 1'b1;

        // R3: idle cycle
        run_cycle('0, '0, '0, "R3");

        // R2 / R7: every lone request, plain and fan-out
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++)
                for (int f = 0; f < 2; f++) begin
                    v = '0; b = '0; d = '0;
                    v[s] = 1'b1; b[s] = f[0]; d[s*AW +: AW] = AW'(t);
                    run_cycle(v, d, b, f ? "R7" : "R2");
                end

        // R4 / R5 / R8: every pair of sources, destinations and flags
        for (int s1 = 0; s1 < N; s1++)
            for (int s2 = s1 + 1; s2 < N; s2++)
                for (int t1 = 0; t1 < N; t1++)
                    for (int t2 = 0; t2 < N; t2++)
                        for (int f = 0; f < 4; f++) begin
                            v = '0; b = '0; d = '0;
                            v[s1] = 1'b1; v[s2] = 1'b1;
                            b[s1] = f[0]; b[s2] = f[1];
                            d[s1*AW +: AW] = AW'(t1); d[s2*AW +: AW] = AW'(t2);
                            run_cycle(v, d, b, (f != 0) ? "R8" : "R5");
                        end

        // R6: cyclic shifts all get through
        for (int c = 0; c < N; c++) begin
            for (int s = 0; s < N; s++) d[s*AW +: AW] = AW'(s + c);
            run_cycle('1, d, '0, "R6");
            checks++;
            if (req_grant !== '1) begin
                errors++;
                $display("FAIL R6 shift %0d grant act=%b exp=%b", c, req_grant, {N{1'b1}});
            end
        end

        // R5 collision example, then R9 retry of the loser alone
        v = '0; d = '0; b = '0;
        v[2] = 1'b1; v[6] = 1'b1;
        d[2*AW +: AW] = 3'd6; d[6*AW +: AW] = 3'd4;
        run_cycle(v, d, b, "R5");
        checks++;
        if (req_grant !== 8'b0000_0100) begin
            errors++;
            $display("FAIL R5 example grant act=%b exp=%b", req_grant, 8'b0000_0100);
        end
        v[2] = 1'b0;
        run_cycle(v, d, b, "R9");
        checks++;
        if (mem_valid !== 8'b0001_0000) begin
            errors++;
            $display("FAIL R9 retry mem_valid act=%b exp=%b", mem_valid, 8'b0001_0000);
        end

        // R4: pseudo-random full patterns
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < N; s++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                d[s*AW +: AW] = lfsr[AW-1:0];
                v[s] = lfsr[5] | lfsr[9];
                b[s] = lfsr[7] & lfsr[11];
            end
            run_cycle(v, d, b, "R4");
        end

        finish_run();
    end

endmodule